// File: doc/BRIEF.md
# Memory Access Attribute Resolver

This block settles the effective attributes of each memory reference that a processor core or a debug unit issues. It holds two programmable address regions and one register of fallback attributes. The upper byte of each incoming address is compared with both regions, and the bits that a region's mask marks are not compared. Region 0 wins whenever it matches. Region 1 is used only when region 0 does not match. When neither region matches, the fallback attributes apply.

Three attribute flags leave the block: cacheable, precise operand-write handling, and write protect. Two more outputs go with them: a hit flag and a 2-bit code that names the source of the attributes. The resolution is combinational from the address and the stored registers. Register writes go through a simple select/data port and take effect on the clock edge that ends the write cycle.

Top module: `attr_resolver`

## Requirements
- R1: After reset both regions are disabled and the fallback flags are zero, so a valid reference resolves with source code 0, hit 0 and all three flags 0.
- R2: A region word has this layout: base in bits [7:0], mask in bits [15:8], enable in bit 16, cacheable in bit 17, precise in bit 18, write protect in bit 19. An enabled region 0 whose base equals address bits [31:24] on every bit where its mask is 0 drives its flags, with source code 1 and hit 1.
- R3: When region 0 and region 1 both match, region 0's flags and source code 1 win.
- R4: When region 0 misses and region 1 matches, region 1's flags are output with source code 2 and hit 1.
- R5: When no region matches, the fallback flags are output (fallback word: cacheable bit 0, precise bit 1, write protect bit 2) with source code 0 and hit 0.
- R6: A region whose enable bit is 0 never matches, whatever its base and mask hold.
- R7: A mask bit of 1 excludes that address bit from the comparison, so an all-ones mask matches every address.
- R8: Write select 0 loads region 0, 1 loads region 1 and 2 loads the fallback word. A reference presented in the same cycle as the write resolves against the old contents, and the new contents apply from the next cycle on.
- R9: A write with select 3 changes no register.
- R10: The debug-origin input has no effect on the result.
- R11: While the reference-valid input is low, all three flags, hit and the source code read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select (0 region 0, 1 region 1, 2 fallback, 3 none) |
| wrData | input | 32 | Write data |
| refValid | input | 1 | Reference present |
| refDebug | input | 1 | Reference comes from the debug unit |
| refAddr | input | 32 | Reference address |
| attrCacheable | output | 1 | Effective cacheable flag |
| attrPrecise | output | 1 | Effective precise-write flag |
| attrWrProt | output | 1 | Effective write-protect flag |
| attrHit | output | 1 | A region matched |
| attrSrc | output | 2 | Source of the attributes (0 fallback, 1 region 0, 2 region 1) |

## Verification
A stored register that is wrong shows up at the ports in the first cycle that a valid reference reaches the corrupted field. A region that matches by mistake shows as a changed source code. A wrong priority shows only when the address falls inside both regions. For that reason the bench keeps its own copy of the registers, compares every output on every clock, and steers many addresses into the overlap of the two regions. A write that lands a cycle early or late shows at once, because the bench makes a reference in the very cycle of each write.

// File: rtl/attr_resolver_pkg.sv
package attr_resolver_pkg;
  localparam int RGN_CNT = 2;

  typedef struct packed {
    logic wrProt;
    logic precise;
    logic cacheable;
  } attr_t;

  typedef struct packed {
    logic               ldDflt;
    logic [RGN_CNT-1:0] ldRgn;
  } ld_strobe_t;

  localparam logic [1:0] SRC_DFLT = 2'd0;
  localparam logic [1:0] SEL_DFLT = 2'd2;
endpackage

// File: rtl/attr_ctrl.sv
module attr_ctrl
  import attr_resolver_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  output ld_strobe_t ld
);
  always_comb begin
    ld = '0;
    if (wrEn) begin
      for (int i = 0; i < RGN_CNT; i++)
        if (wrSel == 2'(i)) ld.ldRgn[i] = 1'b1;
      if (wrSel == SEL_DFLT) ld.ldDflt = 1'b1;
    end
  end

  // R8: at most one register loads per cycle
  a_r8_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld.ldDflt, ld.ldRgn}));
  // R9: select 3 loads nothing
  a_r9_sel3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wrSel == 2'd3) |-> (ld == '0));
endmodule

// File: rtl/attr_datapath.sv
module attr_datapath
  import attr_resolver_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 8,
  parameter int WR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ld_strobe_t        ld,
  input  logic [WR_W-1:0]   wrData,
  input  logic              refValid,
  input  logic [ADDR_W-1:0] refAddr,
  output attr_t             attrOut,
  output logic              hitOut,
  output logic [1:0]        srcOut
);
  localparam int MASK_LSB = CMP_W;
  localparam int EN_BIT   = 2 * CMP_W;
  localparam int ATTR_LSB = EN_BIT + 1;
  localparam int RGN_W    = ATTR_LSB + 3;
  localparam int CMP_LSB  = ADDR_W - CMP_W;

  logic [RGN_W-1:0]   rgnReg [RGN_CNT];
  attr_t              dfltReg;
  logic [RGN_CNT-1:0] rgnMatch;
  logic [CMP_W-1:0]   addrTop;

  assign addrTop = refAddr[ADDR_W-1:CMP_LSB];

  for (genvar g = 0; g < RGN_CNT; g++) begin : gRgn
    logic [CMP_W-1:0] base, mask;
    logic             en;
    assign base = rgnReg[g][CMP_W-1:0];
    assign mask = rgnReg[g][MASK_LSB +: CMP_W];
    assign en   = rgnReg[g][EN_BIT];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            rgnReg[g] <= '0;
      else if (ld.ldRgn[g])  rgnReg[g] <= wrData[RGN_W-1:0];

    assign rgnMatch[g] = en && (((addrTop ^ base) & ~mask) == '0);

    // R6: a region disabled by the previous write cannot win now
    a_r6_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (ld.ldRgn[g] && !wrData[EN_BIT]) |=> (srcOut != 2'(g + 1)));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         dfltReg <= '0;
    else if (ld.ldDflt) dfltReg <= attr_t'(wrData[2:0]);

  always_comb begin
    attrOut = '0;
    hitOut  = 1'b0;
    srcOut  = SRC_DFLT;
    if (refValid) begin
      attrOut = dfltReg;
      for (int i = RGN_CNT - 1; i >= 0; i--) begin
        if (rgnMatch[i]) begin
          attrOut = attr_t'(rgnReg[i][ATTR_LSB +: 3]);
          hitOut  = 1'b1;
          srcOut  = 2'(i + 1);
        end
      end
    end
  end

  // R8: a new fallback word shows on the next fallback-sourced reference
  a_r8_dflt_next: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld.ldDflt) && refValid && srcOut == SRC_DFLT)
      |-> (attrOut == attr_t'($past(wrData[2:0]))));
  // R11: nothing is asserted without a reference
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !refValid |-> (attrOut == '0 && !hitOut && srcOut == SRC_DFLT));
  // R5: hit flag and source code agree
  a_r5_hit_src: assert property (@(posedge clk) disable iff (!rst_n)
    hitOut |-> (srcOut != SRC_DFLT));
  // R8: unchanged address and no write keep the result stable
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(refAddr) && $stable(refValid) && $past(ld) == '0)
      |-> ($stable(attrOut) && $stable(srcOut)));
endmodule

// File: rtl/attr_resolver.sv
module attr_resolver
  import attr_resolver_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 8,
  parameter int WR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [WR_W-1:0]   wrData,
  input  logic              refValid,
  input  logic              refDebug,
  input  logic [ADDR_W-1:0] refAddr,
  output logic              attrCacheable,
  output logic              attrPrecise,
  output logic              attrWrProt,
  output logic              attrHit,
  output logic [1:0]        attrSrc
);
  ld_strobe_t ldStb;
  attr_t      attrEff;
  logic       debugUnused;

  // Core and debug references resolve identically (R10).
  assign debugUnused = refDebug;

  attr_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .ld(ldStb)
  );

  attr_datapath #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .WR_W(WR_W)) uDp (
    .clk(clk), .rst_n(rst_n), .ld(ldStb), .wrData(wrData),
    .refValid(refValid), .refAddr(refAddr),
    .attrOut(attrEff), .hitOut(attrHit), .srcOut(attrSrc)
  );

  assign attrCacheable = attrEff.cacheable;
  assign attrPrecise   = attrEff.precise;
  assign attrWrProt    = attrEff.wrProt;
endmodule

// File: tb/attr_resolver_test.sv
`timescale 1ns/1ps
module attr_resolver_test;
  logic        clk = 0, rst_n = 0;
  logic        wrEn = 0, refValid = 0, refDebug = 0;
  logic [1:0]  wrSel = 0;
  logic [31:0] wrData = 0, refAddr = 0;
  logic        attrCacheable, attrPrecise, attrWrProt, attrHit;
  logic [1:0]  attrSrc;

  int total = 0, bad = 0, cyc = 0;
  string phase = "R1";
  logic [31:0] mRgn [2];
  logic [2:0]  mDflt;

  always #10 clk = ~clk;

  attr_resolver uut (.*);

  // model register file
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mRgn[0] <= 0; mRgn[1] <= 0; mDflt <= 0;
    end else if (wrEn) begin
      if (wrSel == 0) mRgn[0] <= wrData;
      else if (wrSel == 1) mRgn[1] <= wrData;
      else if (wrSel == 2) mDflt <= wrData[2:0];
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit hits(logic [31:0] r, logic [31:0] a);
    logic [7:0] top;
    top = a[31:24];
    if (!r[16]) return 0;
    for (int b = 0; b < 8; b++)
      if (!r[8+b] && (top[b] != r[b])) return 0;
    return 1;
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    logic [2:0] eA; logic eH; logic [1:0] eS;
    if (rst_n) begin
      eA = 0; eH = 0; eS = 0;
      if (refValid) begin
        if (hits(mRgn[0], refAddr))      begin eA = mRgn[0][19:17]; eH = 1; eS = 1; end
        else if (hits(mRgn[1], refAddr)) begin eA = mRgn[1][19:17]; eH = 1; eS = 2; end
        else                              eA = mDflt;
      end
      total++;
      if ({attrWrProt, attrPrecise, attrCacheable, attrHit, attrSrc} != {eA, eH, eS}) begin
        bad++;
        $display("FAIL %s (src R%0d) addr=%h: actual attr=%b hit=%b src=%0d expected attr=%b hit=%b src=%0d",
                 phase, (eS == 1) ? 3 : (eS == 2) ? 4 : 5, refAddr,
                 {attrWrProt, attrPrecise, attrCacheable}, attrHit, attrSrc, eA, eH, eS);
      end
    end
  end

  task automatic step(logic v, logic [31:0] a, logic d = 0,
                      logic we = 0, logic [1:0] s = 0, logic [31:0] wd = 0);
    refValid = v; refAddr = a; refDebug = d;
    wrEn = we; wrSel = s; wrData = wd;
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] rgn(logic [7:0] base, logic [7:0] mask,
                                      logic en, logic [2:0] at);
    return {12'd0, at, en, mask, base};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    phase = "R1 reset state";
    step(1, 32'hA000_0000); step(1, 32'h0000_1234);
    phase = "R5 default";
    step(0, 0, 0, 1, 2, 32'h5);
    step(1, 32'h1234_0000); step(1, 32'hFF00_0000);
    phase = "R6 disabled";
    step(0, 0, 0, 1, 0, rgn(8'h12, 8'h00, 0, 3'b111));
    step(1, 32'h1200_0000);
    phase = "R2 region0 match";
    step(0, 0, 0, 1, 0, rgn(8'h12, 8'h00, 1, 3'b011));
    step(1, 32'h1200_0000); step(1, 32'h12FF_FFFF); step(1, 32'h1300_0000);
    phase = "R7 mask";
    step(0, 0, 0, 1, 1, rgn(8'h40, 8'h0F, 1, 3'b110));
    step(1, 32'h4F00_0000); step(1, 32'h4000_0000); step(1, 32'h5000_0000);
    phase = "R3 overlap priority";
    step(0, 0, 0, 1, 1, rgn(8'h00, 8'hFF, 1, 3'b100));
    step(1, 32'h1200_0000); step(1, 32'h7700_0000);
    phase = "R4 region1 only";
    step(1, 32'hE000_0000);
    phase = "R8 same-cycle write";
    step(1, 32'h1200_0000, 0, 1, 0, rgn(8'h12, 8'h00, 0, 3'b000));
    step(1, 32'h1200_0000);
    step(1, 32'h1200_0000, 0, 1, 2, 32'h3);
    phase = "R9 select 3";
    step(1, 32'h9900_0000, 0, 1, 3, 32'hFFFF_FFFF);
    step(1, 32'h9900_0000);
    phase = "R10 debug origin";
    step(1, 32'h9900_0000, 1); step(1, 32'h1200_0000, 1);
    phase = "R11 idle";
    step(0, 32'h1200_0000); step(0, 32'hFFFF_FFFF, 1);
    phase = "R2 R3 R4 R5 R6 R7 R8 R9 R10 random";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, d;
      a = $urandom; d = $urandom;
      a[31:28] = (i % 3 == 0) ? 4'hA : a[31:28];
      d[7:4]   = 4'hA;
      d[15:12] = ($urandom % 2) ? 4'hF : 4'h0;
      step($urandom % 4 != 0, a, $urandom % 2, $urandom % 5 == 0, 2'($urandom), d);
    end
    step(0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule